// File: doc/BRIEF.md
# Single-Channel Bus-Mastering DMA Controller

This block moves a block of words between one peripheral and memory so that the processor does not copy them itself. The processor loads a start address, a word count and a mode through a small register port that uses chip select, a two-bit register index, a read strobe and a write strobe. It then arms the channel with a start bit. The mode sets the direction, either device to memory or memory to device, and the bus-holding policy.

When the armed channel sees a request from the device, it asks the processor for the system bus. After the grant it acknowledges the device and runs one memory cycle for each word. In each of those cycles the read or write strobe is high for a single clock while the address is driven. After every word the address moves by one and the remaining count drops by one. When the count reaches zero the controller gives up the bus, and the done flag drives the interrupt line to the processor. Reading the status register clears the flag.

In burst mode the controller keeps the bus request high for the whole block, including the gaps where the device has no word ready. In cycle-stealing mode it drops the request after every word and asks again for the next one.

Top module: `dma_engine`

## Requirements
- R1: Register index 0 holds the start address and index 1 the word count; both read back what was written. Index 2 is control: bit 0 write-1 starts, bit 1 selects direction (0 device to memory, 1 memory to device), bit 2 selects burst (1) or cycle stealing (0). Control reads back busy in bit 0 and the stored direction and burst bits. Index 3 is read-only status: bit 0 busy, bit 1 done.
- R2: While armed and idle, the bus request stays low as long as the device request is low. It rises one clock after the device request is first sampled high.
- R3: A memory strobe and the device acknowledge occur only while the bus grant is high. The k-th word (k from 0) uses address start+k, modulo the address width.
- R4: Every word takes exactly one strobe clock. Device to memory pulses the memory write and forwards the device word as write data. Memory to device pulses the memory read and forwards the memory data to the device. The two strobes are never high together.
- R5: After each word the address register advances by one and the count register decreases by one. After a block the address reads start+count and the count reads 0.
- R6: Exactly count words are moved. In the clock after the last strobe the bus request is low, busy is clear, done is set and the interrupt is high.
- R7: In cycle-stealing mode the bus request is low in the clock after every word strobe.
- R8: In burst mode the bus request stays high from its first rise until the block ends, even while the device request is low.
- R9: While busy, writes to the address, count and control registers have no effect.
- R10: The interrupt output equals the done flag. A status read clears both at the next clock edge.
- R11: Starting with a count of zero sets done in the next clock and never raises the bus request.
- R12: After reset all registers, the bus request, the acknowledge, both strobes and the interrupt are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Register port chip select |
| rsel | input | 2 | Register index |
| rd | input | 1 | Register read strobe |
| wr | input | 1 | Register write strobe |
| cpu_wdata | input | DW | Register write data |
| cpu_rdata | output | DW | Register read data (0 when not reading) |
| done_irq | output | 1 | End-of-block interrupt |
| bus_req | output | 1 | Bus request to the processor |
| bus_grant | input | 1 | Bus grant from the processor |
| dev_req | input | 1 | Transfer request from the device |
| dev_ack | output | 1 | Acknowledge to the device during a word cycle |
| dev_din | input | DW | Word from the device |
| dev_dout | output | DW | Word to the device |
| mem_addr | output | AW | Memory address, driven during word cycles |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data |
| mem_wr | output | 1 | One-clock memory write strobe |
| mem_rd | output | 1 | One-clock memory read strobe |

## Verification
The bus request is due one clock after the device request is first seen, and the first strobe one clock after the grant is sampled. The interrupt with the released bus is due in the clock after the last strobe. Register reads are combinational within the cycle. Register writes and the status-read clear take effect at the next edge. The bench drives inputs and samples outputs on the falling edge just after it. Each observation therefore sees the state that the preceding rising edge produced. The grant latency and the device request pattern are drawn at random. Every word is still checked when it happens against an address and data model kept in the bench.

// File: rtl/dma_pkg.sv
package dma_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_REQ  = 2'd1,
      SEQ_XFER = 2'd2,
      SEQ_HOLD = 2'd3
   } seq_state_t;

   localparam logic [1:0] SEL_ADDR  = 2'd0;
   localparam logic [1:0] SEL_COUNT = 2'd1;
   localparam logic [1:0] SEL_CTRL  = 2'd2;
   localparam logic [1:0] SEL_STAT  = 2'd3;

   localparam int CTL_START = 0;
   localparam int CTL_DIR   = 1;
   localparam int CTL_BURST = 2;

   localparam int STA_BUSY  = 0;
   localparam int STA_DONE  = 1;

endpackage

// File: rtl/dma_regs.sv
module dma_regs
   import dma_pkg::*;
#(
   parameter int DW        = 16,
   parameter int AW        = 16,
   parameter int CW        = 16,
   parameter bit ADDR_DOWN = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs,
   input  logic [1:0]    rsel,
   input  logic          rd,
   input  logic          wr,
   input  logic [DW-1:0] wdata,
   input  logic          step,
   output logic [DW-1:0] rdata,
   output logic [AW-1:0] cur_addr,
   output logic          busy,
   output logic          done,
   output logic          xfer_dir,
   output logic          burst,
   output logic          cnt_last
);

   localparam logic [AW-1:0] A_ONE = AW'(1);
   localparam logic [CW-1:0] C_ONE = CW'(1);

   logic [AW-1:0] addr_q, addr_nxt;
   logic [CW-1:0] cnt_q;
   logic          busy_q, done_q, dir_q, burst_q;
   logic          wr_hit, stat_rd;

   assign wr_hit  = cs && wr;
   assign stat_rd = cs && rd && (rsel == SEL_STAT);

   generate
      if (ADDR_DOWN) begin : g_addr_dec
         assign addr_nxt = addr_q - A_ONE;
      end else begin : g_addr_inc
         assign addr_nxt = addr_q + A_ONE;
      end
   endgenerate

   assign cnt_last = (cnt_q == C_ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         cnt_q   <= '0;
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         dir_q   <= 1'b0;
         burst_q <= 1'b0;
      end else begin
         if (stat_rd) begin
            done_q <= 1'b0;
         end
         if (wr_hit && !busy_q) begin
            case (rsel)
               SEL_ADDR:  addr_q <= wdata[AW-1:0];
               SEL_COUNT: cnt_q  <= wdata[CW-1:0];
               SEL_CTRL: begin
                  dir_q   <= wdata[CTL_DIR];
                  burst_q <= wdata[CTL_BURST];
                  if (wdata[CTL_START]) begin
                     if (cnt_q == '0) begin
                        done_q <= 1'b1;
                     end else begin
                        busy_q <= 1'b1;
                        done_q <= 1'b0;
                     end
                  end
               end
               default: ;
            endcase
         end
         if (step && busy_q) begin
            addr_q <= addr_nxt;
            cnt_q  <= cnt_q - C_ONE;
            if (cnt_q == C_ONE) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (cs && rd) begin
         case (rsel)
            SEL_ADDR:  rdata[AW-1:0] = addr_q;
            SEL_COUNT: rdata[CW-1:0] = cnt_q;
            SEL_CTRL: begin
               rdata[CTL_START] = busy_q;
               rdata[CTL_DIR]   = dir_q;
               rdata[CTL_BURST] = burst_q;
            end
            default: begin
               rdata[STA_BUSY] = busy_q;
               rdata[STA_DONE] = done_q;
            end
         endcase
      end
   end

   assign cur_addr = addr_q;
   assign busy     = busy_q;
   assign done     = done_q;
   assign xfer_dir = dir_q;
   assign burst    = burst_q;

endmodule

// File: rtl/dma_seq.sv
module dma_seq
   import dma_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic busy,
   input  logic burst,
   input  logic cnt_last,
   input  logic dev_req,
   input  logic bus_grant,
   output logic bus_req,
   output logic dev_ack,
   output logic step
);

   seq_state_t state_q, state_d;

   always_comb begin
      state_d = state_q;
      case (state_q)
         SEQ_IDLE: if (busy && dev_req) state_d = SEQ_REQ;
         SEQ_REQ:  if (bus_grant)       state_d = SEQ_XFER;
         SEQ_XFER: begin
            if (cnt_last)   state_d = SEQ_IDLE;
            else if (burst) state_d = SEQ_HOLD;
            else            state_d = SEQ_IDLE;
         end
         SEQ_HOLD: begin
            if (!bus_grant)   state_d = SEQ_REQ;
            else if (dev_req) state_d = SEQ_XFER;
         end
         default: state_d = SEQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= SEQ_IDLE;
      else        state_q <= state_d;
   end

   assign bus_req = (state_q != SEQ_IDLE);
   assign dev_ack = (state_q == SEQ_XFER);
   assign step    = (state_q == SEQ_XFER);

endmodule

// File: rtl/dma_busmux.sv
module dma_busmux #(
   parameter int DW = 16,
   parameter int AW = 16
) (
   input  logic          active,
   input  logic          xfer_dir,
   input  logic [AW-1:0] cur_addr,
   input  logic [DW-1:0] dev_din,
   input  logic [DW-1:0] mem_rdata,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   output logic [DW-1:0] dev_dout,
   output logic          mem_wr,
   output logic          mem_rd
);

   assign mem_addr  = active ? cur_addr : '0;
   assign mem_wr    = active && !xfer_dir;
   assign mem_rd    = active &&  xfer_dir;
   assign mem_wdata = mem_wr ? dev_din   : '0;
   assign dev_dout  = mem_rd ? mem_rdata : '0;

endmodule

// File: rtl/dma_engine.sv
module dma_engine #(
   parameter int DW        = 16,
   parameter int AW        = 16,
   parameter int CW        = 16,
   parameter bit ADDR_DOWN = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs,
   input  logic [1:0]    rsel,
   input  logic          rd,
   input  logic          wr,
   input  logic [DW-1:0] cpu_wdata,
   output logic [DW-1:0] cpu_rdata,
   output logic          done_irq,
   output logic          bus_req,
   input  logic          bus_grant,
   input  logic          dev_req,
   output logic          dev_ack,
   input  logic [DW-1:0] dev_din,
   output logic [DW-1:0] dev_dout,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   output logic          mem_wr,
   output logic          mem_rd
);

   generate
      if (AW > DW) begin : g_bad_aw
         $error("dma_engine: AW must not exceed DW");
      end
      if (CW > DW) begin : g_bad_cw
         $error("dma_engine: CW must not exceed DW");
      end
      if (DW < 3) begin : g_bad_dw
         $error("dma_engine: DW must hold the control bits");
      end
   endgenerate

   logic [AW-1:0] cur_addr;
   logic          busy, done, ctl_dir, ctl_burst, cnt_last, step;

   dma_regs #(.DW(DW), .AW(AW), .CW(CW), .ADDR_DOWN(ADDR_DOWN)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs       (cs),
      .rsel     (rsel),
      .rd       (rd),
      .wr       (wr),
      .wdata    (cpu_wdata),
      .step     (step),
      .rdata    (cpu_rdata),
      .cur_addr (cur_addr),
      .busy     (busy),
      .done     (done),
      .xfer_dir (ctl_dir),
      .burst    (ctl_burst),
      .cnt_last (cnt_last)
   );

   dma_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .busy      (busy),
      .burst     (ctl_burst),
      .cnt_last  (cnt_last),
      .dev_req   (dev_req),
      .bus_grant (bus_grant),
      .bus_req   (bus_req),
      .dev_ack   (dev_ack),
      .step      (step)
   );

   dma_busmux #(.DW(DW), .AW(AW)) u_mux (
      .active    (step),
      .xfer_dir  (ctl_dir),
      .cur_addr  (cur_addr),
      .dev_din   (dev_din),
      .mem_rdata (mem_rdata),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .dev_dout  (dev_dout),
      .mem_wr    (mem_wr),
      .mem_rd    (mem_rd)
   );

   assign done_irq = done;

endmodule

// File: rtl/dma_engine_sva.sv
module dma_engine_sva #(
   parameter int AW        = 16,
   parameter bit ADDR_DOWN = 1'b0
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bus_req,
   input logic          bus_grant,
   input logic          dev_ack,
   input logic          mem_wr,
   input logic          mem_rd,
   input logic          done_irq,
   input logic          busy,
   input logic          burst,
   input logic          step,
   input logic [AW-1:0] cur_addr
);

   localparam logic [AW-1:0] ONE = AW'(1);

   // R3: no memory cycle or acknowledge without the grant
   a_r3_grant_before_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr || mem_rd) |-> (bus_grant && dev_ack));

   // R4: a word strobe lasts one clock only
   a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr || mem_rd) |=> !(mem_wr || mem_rd));

   // R4: read and write strobes exclusive
   a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_wr && mem_rd));

   // R5: address moves by one after each word
   a_r5_addr_advance: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> (cur_addr == (ADDR_DOWN ? $past(cur_addr) - ONE : $past(cur_addr) + ONE)));

   // R6: interrupt only appears with the bus released
   a_r6_irq_bus_free: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_irq) |-> !bus_req);

   // R7: cycle stealing gives the bus back after each word
   a_r7_steal_release: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !burst) |=> !bus_req);

   // R9: address frozen while busy between words
   a_r9_addr_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !step) |=> $stable(cur_addr));

   // R11, R12: no bus request unless armed
   a_r12_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !bus_req);

endmodule

bind dma_engine dma_engine_sva #(.AW(AW), .ADDR_DOWN(ADDR_DOWN)) u_sva (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_req   (bus_req),
   .bus_grant (bus_grant),
   .dev_ack   (dev_ack),
   .mem_wr    (mem_wr),
   .mem_rd    (mem_rd),
   .done_irq  (done_irq),
   .busy      (busy),
   .burst     (ctl_burst),
   .step      (step),
   .cur_addr  (cur_addr)
);

// File: tb/tb_dma_engine.sv
`timescale 1ns/1ps
module tb_dma_engine;

   localparam int DW = 16;
   localparam int AW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cs = 1'b0, rd = 1'b0, wr = 1'b0;
   logic [1:0]    rsel = 2'd0;
   logic [DW-1:0] cpu_wdata = '0;
   logic [DW-1:0] cpu_rdata;
   logic          done_irq, bus_req, dev_ack, mem_wr, mem_rd;
   logic          bus_grant = 1'b0;
   logic          dev_req = 1'b0;
   logic [DW-1:0] dev_din = '0;
   logic [DW-1:0] dev_dout, mem_wdata, mem_rdata;
   logic [AW-1:0] mem_addr;

   int n_checks = 0;
   int n_errors = 0;

   bit          dreq_rand = 1'b0;
   bit          m_on = 1'b0, m_done = 1'b0, m_prev = 1'b0;
   bit          m_seen_br = 1'b0, m_dropped = 1'b0, m_dir = 1'b0, m_burst = 1'b0;
   logic [15:0] m_base = '0, m_cnt = '0, m_k = '0;

   always #10 clk = ~clk;

   dma_engine #(.DW(DW), .AW(AW), .CW(16)) dut (
      .clk(clk), .rst_n(rst_n), .cs(cs), .rsel(rsel), .rd(rd), .wr(wr),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .done_irq(done_irq),
      .bus_req(bus_req), .bus_grant(bus_grant), .dev_req(dev_req),
      .dev_ack(dev_ack), .dev_din(dev_din), .dev_dout(dev_dout),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .mem_wr(mem_wr), .mem_rd(mem_rd)
   );

   function automatic logic [15:0] mem_fn(input logic [15:0] a);
      return (a * 16'd3) ^ 16'h5A3C;
   endfunction

   function automatic logic [15:0] dev_word(input logic [15:0] k);
      return (k * 16'h1357) + 16'h0F0F;
   endfunction

   assign mem_rdata = mem_fn(mem_addr);

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cpu_write(input logic [1:0] sel, input logic [15:0] d);
      @(negedge clk);
      cs = 1'b1; wr = 1'b1; rsel = sel; cpu_wdata = d;
      @(negedge clk);
      cs = 1'b0; wr = 1'b0;
   endtask

   task automatic cpu_read(input logic [1:0] sel, output logic [15:0] d);
      @(negedge clk);
      cs = 1'b1; rd = 1'b1; rsel = sel;
      #1 d = cpu_rdata;
      @(negedge clk);
      cs = 1'b0; rd = 1'b0;
   endtask

   // grant model with random latency
   initial begin
      int lat;
      lat = 0;
      forever begin
         @(negedge clk);
         if (!bus_req) begin
            bus_grant = 1'b0;
            lat = int'($urandom % 3);
         end else if (!bus_grant) begin
            if (lat == 0) bus_grant = 1'b1;
            else lat--;
         end
      end
   end

   // random device request
   initial begin
      forever begin
         @(negedge clk);
         if (dreq_rand) dev_req = (($urandom % 4) != 0);
      end
   end

   // word monitor
   initial begin
      bit strobe;
      forever begin
         @(negedge clk);
         #1;
         strobe = mem_wr || mem_rd;
         if (!m_on) begin
            if (strobe && rst_n) chk(1'b0, "R11 unexpected word strobe", 32'd1, 32'd0);
         end else begin
            if (m_prev) begin
               if (m_k == m_cnt) begin
                  chk(done_irq && !bus_req, "R6 irq high and bus free after last word",
                      {done_irq, bus_req}, 32'h2);
                  m_done = 1'b1;
                  m_on = 1'b0;
               end else if (!m_burst) begin
                  chk(!bus_req, "R7 request dropped after word", bus_req, 32'd0);
               end
            end
            if (m_on) begin
               if (bus_req) m_seen_br = 1'b1;
               else if (m_seen_br && m_k < m_cnt) m_dropped = 1'b1;
               if (strobe) begin
                  chk(m_k < m_cnt, "R6 no extra word", m_k, m_cnt);
                  chk(dev_ack && bus_grant, "R3 ack and grant during word",
                      {dev_ack, bus_grant}, 32'h3);
                  chk(mem_addr == 16'(m_base + m_k), "R3 word address", mem_addr,
                      16'(m_base + m_k));
                  if (m_dir) begin
                     chk(mem_rd && !mem_wr, "R4 read strobe for memory to device",
                         {mem_rd, mem_wr}, 32'h2);
                     chk(dev_dout == mem_fn(mem_addr), "R4 data to device", dev_dout,
                         mem_fn(mem_addr));
                  end else begin
                     chk(mem_wr && !mem_rd, "R4 write strobe for device to memory",
                         {mem_wr, mem_rd}, 32'h2);
                     chk(mem_wdata == dev_word(m_k), "R4 data to memory", mem_wdata,
                         dev_word(m_k));
                  end
                  m_k = m_k + 16'd1;
                  dev_din = dev_word(m_k);
               end
            end
            m_prev = strobe;
         end
      end
   end

   task automatic arm_monitor(input logic [15:0] base, input logic [15:0] cnt,
                              input bit dir, input bit bst);
      m_base = base; m_cnt = cnt; m_dir = dir; m_burst = bst; m_k = '0;
      m_prev = 1'b0; m_seen_br = 1'b0; m_dropped = 1'b0; m_done = 1'b0;
      dev_din = dev_word(16'd0);
      m_on = 1'b1;
   endtask

   task automatic finish_block(input logic [15:0] base, input logic [15:0] cnt, input bit bst);
      logic [15:0] v;
      for (int c = 0; c < 4000 && !m_done; c++) @(negedge clk);
      chk(m_done, "R6 block completes with count words", m_k, cnt);
      if (bst) chk(!m_dropped, "R8 burst holds request", m_dropped, 32'd0);
      chk(done_irq, "R10 irq mirrors done", done_irq, 32'd1);
      cpu_read(2'd3, v);
      chk(v == 16'h2, "R6 status done and not busy", v, 32'h2);
      chk(!done_irq, "R10 irq cleared by status read", done_irq, 32'd0);
      cpu_read(2'd3, v);
      chk(v == 16'h0, "R10 done cleared", v, 32'h0);
      cpu_read(2'd1, v);
      chk(v == 16'h0, "R5 count ends at zero", v, 32'h0);
      cpu_read(2'd0, v);
      chk(v == 16'(base + cnt), "R5 address ends at start plus count", v, 16'(base + cnt));
   endtask

   task automatic run_block(input logic [15:0] base, input logic [15:0] cnt,
                            input bit dir, input bit bst);
      cpu_write(2'd0, base);
      cpu_write(2'd1, cnt);
      arm_monitor(base, cnt, dir, bst);
      cpu_write(2'd2, {13'd0, bst, dir, 1'b1});
      finish_block(base, cnt, bst);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_errors++;
      $display("FAIL R6 watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end

   initial begin
      logic [15:0] v;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      // R12 reset state
      chk({bus_req, dev_ack, mem_wr, mem_rd, done_irq} == 5'b0, "R12 outputs idle after reset",
          {bus_req, dev_ack, mem_wr, mem_rd, done_irq}, 32'd0);
      cpu_read(2'd3, v); chk(v == 16'h0, "R12 status zero", v, 32'h0);
      cpu_read(2'd0, v); chk(v == 16'h0, "R12 address zero", v, 32'h0);
      cpu_read(2'd1, v); chk(v == 16'h0, "R12 count zero", v, 32'h0);

      // R1 readback
      cpu_write(2'd0, 16'h1234);
      cpu_write(2'd1, 16'h0005);
      cpu_write(2'd2, 16'h0006);
      cpu_read(2'd0, v); chk(v == 16'h1234, "R1 address readback", v, 32'h1234);
      cpu_read(2'd1, v); chk(v == 16'h0005, "R1 count readback", v, 32'h5);
      cpu_read(2'd2, v); chk(v == 16'h0006, "R1 control readback", v, 32'h6);

      // R2 and R9: armed, no device request yet
      dev_req = 1'b0;
      cpu_write(2'd0, 16'h0040);
      cpu_write(2'd1, 16'h0002);
      arm_monitor(16'h0040, 16'h0002, 1'b0, 1'b0);
      cpu_write(2'd2, 16'h0001);
      repeat (4) @(negedge clk);
      #1 chk(!bus_req, "R2 no request without device request", bus_req, 32'd0);
      cpu_read(2'd3, v); chk(v == 16'h1, "R1 status busy", v, 32'h1);
      cpu_write(2'd0, 16'h0999);
      cpu_write(2'd1, 16'h0007);
      cpu_write(2'd2, 16'h0006);
      cpu_read(2'd0, v); chk(v == 16'h0040, "R9 address write ignored", v, 32'h40);
      cpu_read(2'd1, v); chk(v == 16'h0002, "R9 count write ignored", v, 32'h2);
      cpu_read(2'd2, v); chk(v == 16'h0001, "R9 control write ignored", v, 32'h1);
      @(negedge clk);
      dev_req = 1'b1;
      @(negedge clk);
      #1 chk(bus_req, "R2 request one clock after device request", bus_req, 32'd1);
      finish_block(16'h0040, 16'h0002, 1'b0);

      // R11 zero count
      cpu_write(2'd1, 16'h0000);
      cpu_write(2'd2, 16'h0001);
      #1 chk(done_irq && !bus_req, "R11 zero count done at once", {done_irq, bus_req}, 32'h2);
      repeat (4) @(negedge clk);
      #1 chk(!bus_req, "R11 zero count never requests", bus_req, 32'd0);
      cpu_read(2'd3, v); chk(v == 16'h2, "R11 status done not busy", v, 32'h2);
      chk(!done_irq, "R10 irq cleared after zero count", done_irq, 32'd0);

      // burst memory to device with random request
      dreq_rand = 1'b1;
      run_block(16'h0100, 16'd6, 1'b1, 1'b1);
      // address wrap
      run_block(16'hFFFE, 16'd4, 1'b0, 1'b1);
      // cycle stealing memory to device
      run_block(16'h2000, 16'd5, 1'b1, 1'b0);

      for (int i = 0; i < 10; i++) begin
         logic [15:0] b, n;
         bit dd, bb;
         b  = 16'($urandom);
         n  = 16'(1 + ($urandom % 12));
         dd = 1'($urandom);
         bb = 1'($urandom);
         run_block(b, n, dd, bb);
      end

      repeat (3) @(negedge clk);
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end

endmodule